// File: doc/BRIEF.md
# ECC error status and capture unit

This unit is the register block that sits next to a memory controller's ECC datapath. It takes three kinds of error events: out-of-range accesses from the address checker, and correctable or uncorrectable results from the ECC decoder. For each kind it keeps a first-event flag and an overflow flag. On the first event of a kind it captures the address, and for ECC errors also the data word. Correctable and uncorrectable errors have separate capture sets. The unit also records the syndrome of the most recent ECC error. A completion flag for memory initialisation sits in the same status word.

Software reads and writes the unit through a flat word-addressed register port. Status flags are cleared by writing ones to them. A mask register decides which flags reach the interrupt line. A two-bit mode register drives two enables to the datapath: one lets writes update check storage, the other lets reads be checked and corrected. Turning check updates off while reads are still checked lets software write data with stale check bits, which injects errors on purpose.

Top module: `ecc_err_status`

## Requirements
- R1: After reset, every status flag, capture register and the syndrome read as 0, the mask reads 0x7F (all sources masked), the mode reads 2 (full ECC), both datapath enables are 1, and irq is 0.
- R2: An `ev_range` pulse sets status bit 0 when that bit is clear and captures the 64-bit address: low word at register 3, high word at register 4. A pulse while bit 0 is already set leaves the capture unchanged and sets bit 1.
- R3: An accepted correctable event sets status bit 2 when it is clear and captures the address at register 5, data bits 31:0 at register 6 and data bits 63:32 at register 7. A further correctable event while bit 2 is set only sets bit 3 and leaves the capture unchanged.
- R4: Uncorrectable events behave in the same way with status bits 4 (first) and 5 (multiple) and their own capture set at registers 8, 9 and 10. The correctable set is not touched.
- R5: An `init_done` pulse sets status bit 6.
- R6: Status register 0 shows in bits 23:16 the syndrome of the most recently accepted correctable or uncorrectable event. Writing status bits does not change it.
- R7: Writing register 0 with a 1 in any of bits 6:0 clears those status bits. Bits written as 0 keep their value. The next event of a cleared kind is a first event and captures again.
- R8: When an acknowledge of a first-event bit and a new event of the same kind arrive in the same cycle, the event wins: the first-event bit stays set, the new event is captured, and the multiple bit is not set.
- R9: Register 1 bits 6:0 hold the mask, where 1 masks a status bit. irq is 1 exactly when some status bit is set and not masked.
- R10: Register 2 bits 1:0 hold the mode. The enables are `chk_upd_en`/`chk_rd_en`: mode 2 (full) gives 1/1, mode 1 (no check update) gives 0/1, mode 0 (check storage detached) gives 0/0, and mode 3 also gives 0/0.
- R11: While `chk_rd_en` is 0, decoder events are ignored: no status bit, capture or syndrome changes.
- R12: Unmapped addresses (11 to 15) read 0, and writes to capture registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ev_range | input | 1 | Out-of-range access event |
| ev_range_addr | input | 64 | Address of the out-of-range access |
| ev_corr | input | 1 | Correctable error from the decoder |
| ev_uncorr | input | 1 | Uncorrectable error from the decoder |
| ev_addr | input | 32 | Address of the decoded access |
| ev_data | input | 64 | Data word of the decoded access |
| ev_syndrome | input | 8 | Syndrome of the decoded access |
| init_done | input | 1 | Memory initialisation complete pulse |
| chk_upd_en | output | 1 | Writes update check storage |
| chk_rd_en | output | 1 | Reads are checked and corrected |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
Every event, acknowledge and register write is sampled on one rising edge and shows up in the flags, captures, syndrome, mode enables and irq right after that edge. Read data is combinational, so a read needs no extra cycle. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and reads results back on the next falling edge. After reset it waits for the two-stage release to finish before its first check.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 4;
  localparam int SYN_W   = 8;
  localparam int EADDR_W = 32;
  localparam int EDATA_W = 64;
  localparam int RADDR_W = 64;
  localparam int NSTAT   = 7;
  localparam int ECAP_W  = EADDR_W + EDATA_W;

  localparam logic [REG_AW-1:0] A_STAT    = 4'd0;
  localparam logic [REG_AW-1:0] A_MASK    = 4'd1;
  localparam logic [REG_AW-1:0] A_MODE    = 4'd2;
  localparam logic [REG_AW-1:0] A_RNG_LO  = 4'd3;
  localparam logic [REG_AW-1:0] A_RNG_HI  = 4'd4;
  localparam logic [REG_AW-1:0] A_COR_ADR = 4'd5;
  localparam logic [REG_AW-1:0] A_COR_DLO = 4'd6;
  localparam logic [REG_AW-1:0] A_COR_DHI = 4'd7;
  localparam logic [REG_AW-1:0] A_UNC_ADR = 4'd8;
  localparam logic [REG_AW-1:0] A_UNC_DLO = 4'd9;
  localparam logic [REG_AW-1:0] A_UNC_DHI = 4'd10;

  typedef enum logic [1:0] {
    MODE_DETACH = 2'b00,
    MODE_NOUPD  = 2'b01,
    MODE_FULL   = 2'b10,
    MODE_RSVD   = 2'b11
  } ecc_mode_e;
endpackage

// File: rtl/ecc_evt_slot.sv
// One error class: first-event flag, overflow flag, first-event capture.
module ecc_evt_slot #(
  parameter int CAP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             ack_first,
  input  logic             ack_multi,
  input  logic [CAP_W-1:0] cap_in,
  output logic             first_q,
  output logic             multi_q,
  output logic [CAP_W-1:0] cap_q
);
  logic             occupied;
  logic             load;
  logic             first_d;
  logic             multi_d;
  logic [CAP_W-1:0] cap_d;

  always_comb begin
    // A flag being acknowledged this cycle no longer blocks a fresh capture.
    occupied = first_q & ~ack_first;
    load     = ev & ~occupied;
    first_d  = occupied | ev;
    multi_d  = (multi_q & ~ack_multi) | (ev & occupied);
    cap_d    = load ? cap_in : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      multi_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      first_q <= first_d;
      multi_q <= multi_d;
      cap_q   <= cap_d;
    end
  end
endmodule

// File: rtl/ecc_mode_dec.sv
module ecc_mode_dec
  import ecc_stat_pkg::*;
(
  input  ecc_mode_e mode,
  output logic      upd_en,
  output logic      rd_en
);
  always_comb begin
    unique case (mode)
      MODE_FULL:  begin upd_en = 1'b1; rd_en = 1'b1; end
      MODE_NOUPD: begin upd_en = 1'b0; rd_en = 1'b1; end
      default:    begin upd_en = 1'b0; rd_en = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ecc_reg_rd.sv
module ecc_reg_rd
  import ecc_stat_pkg::*;
(
  input  logic [REG_AW-1:0]  addr,
  input  logic [NSTAT-1:0]   stat,
  input  logic [SYN_W-1:0]   syn,
  input  logic [NSTAT-1:0]   mask,
  input  ecc_mode_e          mode,
  input  logic [RADDR_W-1:0] rng_cap,
  input  logic [ECAP_W-1:0]  cor_cap,
  input  logic [ECAP_W-1:0]  unc_cap,
  output logic [REG_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_STAT:    begin rdata[NSTAT-1:0] = stat; rdata[23:16] = syn; end
      A_MASK:    rdata[NSTAT-1:0] = mask;
      A_MODE:    rdata[1:0] = mode;
      A_RNG_LO:  rdata = rng_cap[31:0];
      A_RNG_HI:  rdata = rng_cap[63:32];
      A_COR_ADR: rdata = cor_cap[31:0];
      A_COR_DLO: rdata = cor_cap[63:32];
      A_COR_DHI: rdata = cor_cap[95:64];
      A_UNC_ADR: rdata = unc_cap[31:0];
      A_UNC_DLO: rdata = unc_cap[63:32];
      A_UNC_DHI: rdata = unc_cap[95:64];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               ev_range,
  input  logic [RADDR_W-1:0] ev_range_addr,
  input  logic               ev_corr,
  input  logic               ev_uncorr,
  input  logic [EADDR_W-1:0] ev_addr,
  input  logic [EDATA_W-1:0] ev_data,
  input  logic [SYN_W-1:0]   ev_syndrome,
  input  logic               init_done,
  output logic               chk_upd_en,
  output logic               chk_rd_en,
  output logic               irq
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                stat_wr, mask_wr, mode_wr;
  logic [NSTAT-1:0]    ack;
  logic                corr_acc, unc_acc;
  logic [NSTAT-1:0]    stat;
  logic [NSTAT-1:0]    mask_q, mask_d;
  ecc_mode_e           mode_q, mode_d;
  logic [SYN_W-1:0]    syn_q, syn_d;
  logic                init_q, init_d;
  logic                rng_first, rng_multi;
  logic                cor_first, cor_multi;
  logic                unc_first, unc_multi;
  logic [RADDR_W-1:0]  rng_cap;
  logic [ECAP_W-1:0]   corr_cap;
  logic [ECAP_W-1:0]   unc_cap;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:NSTAT];

  always_comb begin
    stat_wr  = reg_wr && (reg_addr == A_STAT);
    mask_wr  = reg_wr && (reg_addr == A_MASK);
    mode_wr  = reg_wr && (reg_addr == A_MODE);
    ack      = stat_wr ? reg_wdata[NSTAT-1:0] : '0;
    corr_acc = ev_corr   & chk_rd_en;
    unc_acc  = ev_uncorr & chk_rd_en;
  end

  ecc_evt_slot #(.CAP_W(RADDR_W)) u_rng (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev_range),
    .ack_first(ack[0]), .ack_multi(ack[1]), .cap_in(ev_range_addr),
    .first_q(rng_first), .multi_q(rng_multi), .cap_q(rng_cap));

  ecc_evt_slot #(.CAP_W(ECAP_W)) u_cor (
    .clk(clk), .rst_n(rst_sync_n), .ev(corr_acc),
    .ack_first(ack[2]), .ack_multi(ack[3]), .cap_in({ev_data, ev_addr}),
    .first_q(cor_first), .multi_q(cor_multi), .cap_q(corr_cap));

  ecc_evt_slot #(.CAP_W(ECAP_W)) u_unc (
    .clk(clk), .rst_n(rst_sync_n), .ev(unc_acc),
    .ack_first(ack[4]), .ack_multi(ack[5]), .cap_in({ev_data, ev_addr}),
    .first_q(unc_first), .multi_q(unc_multi), .cap_q(unc_cap));

  // Next-state logic for the registers local to the top.
  always_comb begin
    init_d = (init_q & ~ack[6]) | init_done;
    syn_d  = (corr_acc | unc_acc) ? ev_syndrome : syn_q;
    mask_d = mask_wr ? reg_wdata[NSTAT-1:0] : mask_q;
    mode_d = mode_wr ? ecc_mode_e'(reg_wdata[1:0]) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      init_q <= 1'b0;
      syn_q  <= '0;
      mask_q <= '1;
      mode_q <= MODE_FULL;
    end else begin
      init_q <= init_d;
      syn_q  <= syn_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  assign stat = {init_q, unc_multi, unc_first, cor_multi, cor_first,
                 rng_multi, rng_first};
  assign irq  = |(stat & ~mask_q);

  ecc_mode_dec u_mode (
    .mode(mode_q), .upd_en(chk_upd_en), .rd_en(chk_rd_en));

  ecc_reg_rd u_rd (
    .addr(reg_addr), .stat(stat), .syn(syn_q), .mask(mask_q),
    .mode(mode_q), .rng_cap(rng_cap), .cor_cap(corr_cap),
    .unc_cap(unc_cap), .rdata(reg_rdata));
endmodule

// File: rtl/ecc_err_status_chk.sv
module ecc_err_status_chk
  import ecc_stat_pkg::*;
(
  input logic               clk,
  input logic               rst_sync_n,
  input logic               reg_wr,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic               ev_range,
  input logic               ev_corr,
  input logic               ev_uncorr,
  input logic               chk_rd_en,
  input logic               irq,
  input logic [NSTAT-1:0]   stat,
  input logic [ECAP_W-1:0]  corr_cap
);
  p_range_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_range |=> stat[0]);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[2] && !(ev_corr && chk_rd_en))
    |=> !stat[2]);

  p_capture_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat[2] && !(reg_wr && reg_addr == A_STAT && reg_wdata[2]))
    |=> $stable(corr_cap));

  p_gate_off_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!chk_rd_en && !(reg_wr && reg_addr == A_STAT))
    |=> $stable(stat[5:2]));

  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == A_MASK && reg_wdata[NSTAT-1:0] == 7'h7F)
    |=> !irq);

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_uncorr && chk_rd_en && reg_wr && reg_addr == A_STAT && reg_wdata[4])
    |=> stat[4]);
endmodule

bind ecc_err_status ecc_err_status_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_range(ev_range), .ev_corr(ev_corr),
  .ev_uncorr(ev_uncorr), .chk_rd_en(chk_rd_en), .irq(irq), .stat(stat),
  .corr_cap(corr_cap));

// File: tb/tb_ecc_err_status.sv
module tb_ecc_err_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ev_range;
  logic [63:0] ev_range_addr;
  logic        ev_corr, ev_uncorr;
  logic [31:0] ev_addr;
  logic [63:0] ev_data;
  logic [7:0]  ev_syndrome;
  logic        init_done;
  logic        chk_upd_en, chk_rd_en, irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ecc_err_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_range(ev_range),
    .ev_range_addr(ev_range_addr), .ev_corr(ev_corr), .ev_uncorr(ev_uncorr),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_syndrome(ev_syndrome),
    .init_done(init_done), .chk_upd_en(chk_upd_en), .chk_rd_en(chk_rd_en),
    .irq(irq));

  // Vector: [31] corr, [30] uncorr, [29:23] ack, [22:15] syndrome,
  //         [14:8] expected status, [7:0] expected recorded syndrome.
  localparam logic [31:0] VEC [8] = '{
    {1'b1, 1'b0, 7'h00, 8'h11, 7'h04, 8'h11},
    {1'b1, 1'b0, 7'h00, 8'h22, 7'h0C, 8'h22},
    {1'b0, 1'b0, 7'h0C, 8'h00, 7'h00, 8'h22},
    {1'b0, 1'b1, 7'h00, 8'h33, 7'h10, 8'h33},
    {1'b1, 1'b1, 7'h00, 8'h44, 7'h34, 8'h44},
    {1'b1, 1'b0, 7'h04, 8'h55, 7'h34, 8'h55},
    {1'b0, 1'b0, 7'h7F, 8'h00, 7'h00, 8'h55},
    {1'b0, 1'b1, 7'h10, 8'h66, 7'h10, 8'h66}
  };

  function automatic logic [31:0] addr_of(int i);
    return 32'h0000_1000 + 32'(i * 8);
  endfunction
  function automatic logic [63:0] data_of(int i);
    return {32'hC0DE_0000 + 32'(i), 32'hBEEF_0000 + 32'(i)};
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; ev_range = 1'b0; ev_corr = 1'b0; ev_uncorr = 1'b0;
    init_done = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        report();
      end
    end
  end

  initial begin
    logic [6:0] prev;
    int         cap_c, cap_u;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_range = 1'b0; ev_range_addr = '0; ev_corr = 1'b0; ev_uncorr = 1'b0;
    ev_addr = '0; ev_data = '0; ev_syndrome = '0; init_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd("R1 stat", 4'd0, 32'h0);
    rd("R1 mask", 4'd1, 32'h7F);
    rd("R1 mode", 4'd2, 32'h2);
    rd("R1 corr addr", 4'd5, 32'h0);
    rd("R1 unc data hi", 4'd10, 32'h0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 enables", 64'({chk_upd_en, chk_rd_en}), 64'd3);

    // Table walk: R3 R4 R6 R7 R8 on decoder events
    prev = '0; cap_c = -1; cap_u = -1;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VEC[i];
      ev_corr = v[31]; ev_uncorr = v[30];
      ev_syndrome = v[22:15]; ev_addr = addr_of(i); ev_data = data_of(i);
      reg_wr = (v[29:23] != 7'h00); reg_addr = 4'd0;
      reg_wdata = {25'd0, v[29:23]};
      if (v[31] && (!prev[2] || v[25])) cap_c = i;
      if (v[30] && (!prev[4] || v[27])) cap_u = i;
      cyc();
      rd("R3/R4/R7/R8 status", 4'd0, {8'd0, v[7:0], 9'd0, v[14:8]});
      prev = v[14:8];
    end
    rd("R3 corr addr", 4'd5, addr_of(cap_c));
    rd("R3 corr data lo", 4'd6, data_of(cap_c)[31:0]);
    rd("R3 corr data hi", 4'd7, data_of(cap_c)[63:32]);
    rd("R4 unc addr", 4'd8, addr_of(cap_u));
    rd("R4 unc data lo", 4'd9, data_of(cap_u)[31:0]);
    rd("R4 unc data hi", 4'd10, data_of(cap_u)[63:32]);

    // R2: out-of-range events
    wr(4'd0, 32'h7F);
    ev_range = 1'b1; ev_range_addr = 64'h0000_0012_3456_7890; cyc();
    rd("R2 first", 4'd0, 32'h0066_0001);
    rd("R2 addr lo", 4'd3, 32'h3456_7890);
    rd("R2 addr hi", 4'd4, 32'h0000_0012);
    ev_range = 1'b1; ev_range_addr = 64'hAAAA_BBBB_CCCC_DDDD; cyc();
    rd("R2 multiple", 4'd0, 32'h0066_0003);
    rd("R2 capture held", 4'd3, 32'h3456_7890);
    // R8: ack and range event together
    ev_range = 1'b1; ev_range_addr = 64'h0000_0077_0000_0042;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h3; cyc();
    rd("R8 range kept", 4'd0, 32'h0066_0001);
    rd("R8 range recaptured", 4'd3, 32'h0000_0042);

    // R5 and R9
    wr(4'd0, 32'h7F);
    init_done = 1'b1; cyc();
    rd("R5 init flag", 4'd0, 32'h0066_0040);
    check("R9 masked irq", 64'(irq), 64'd0);
    wr(4'd1, 32'h3F);
    check("R9 unmasked irq", 64'(irq), 64'd1);
    wr(4'd0, 32'h40);
    check("R9 irq after ack", 64'(irq), 64'd0);
    wr(4'd1, 32'h7F);

    // R10 and R11
    wr(4'd2, 32'h1);
    check("R10 mode1 enables", 64'({chk_upd_en, chk_rd_en}), 64'd1);
    ev_corr = 1'b1; ev_syndrome = 8'h5A; ev_addr = 32'h2000; cyc();
    rd("R10 mode1 still checks", 4'd0, 32'h005A_0004);
    wr(4'd0, 32'h7F);
    wr(4'd2, 32'h0);
    check("R10 mode0 enables", 64'({chk_upd_en, chk_rd_en}), 64'd0);
    ev_corr = 1'b1; ev_uncorr = 1'b1; ev_syndrome = 8'h77;
    ev_addr = 32'h3000; cyc();
    rd("R11 ignored status", 4'd0, 32'h005A_0000);
    rd("R11 ignored capture", 4'd5, 32'h0000_2000);
    wr(4'd2, 32'h3);
    check("R10 mode3 enables", 64'({chk_upd_en, chk_rd_en}), 64'd0);
    wr(4'd2, 32'h2);
    check("R10 mode2 enables", 64'({chk_upd_en, chk_rd_en}), 64'd3);

    // R12
    rd("R12 unmapped", 4'd15, 32'h0);
    rd("R12 unmapped 11", 4'd11, 32'h0);
    wr(4'd5, 32'hFFFF_FFFF);
    rd("R12 capture read-only", 4'd5, 32'h0000_2000);

    report();
  end
endmodule